// File: doc/BRIEF.md
# Bitwise Open-Drain Bus Arbiter

This block decides, frame by frame, which of several controllers sharing a time-division serial line may use a common control channel and a signalling data channel. The line is wired-AND: any controller can pull it low, and a released line reads back as 1. One fixed octet of each frame is reserved for arbitration. A single-bit "bus free" flag in that octet tells contenders whether an owner already holds the bus. The low bits of the octet carry the contenders' addresses.

When the flag reads back free and the block has a request pending, it sends its 3-bit address most significant bit first. It pulls the line low for 0 bits and releases it for 1 bits, and it compares every bit with the value read back. A 1 that comes back as 0 means a contender with a lower address is present. The block then stops sending at once. A block that reads back its whole address intact wins. It raises a one-cycle win strobe so that data can start in the same frame. In every later frame it pulls the flag low to hold the bus, until its request drops. A block that loses tries again in the next frame.

The frame position is driven by two inputs: a bit strobe that marks the end of each bit slot, and a frame-end strobe. The arbitration function is active only when a 3-bit mode field selects it.

Top module: `odbus_arbiter`

## Requirements
- R1: The block pulls the line low only in two places of the arbitration octet: the flag slot (bit 5, the third slot sent) and the address slots (bits 2..0, the last three slots). Octets are sent bit 7 first. It drives nothing before the first frame-end strobe.
- R2: Arbitration starts only if the flag slot reads back 1 (bus free) and a request is pending.
- R3: A request is pending when either the software request input or the data-transmit request input is high.
- R4: Address bits go out most significant first, in bit order 2, 1, 0. A 0 bit pulls the line low and a 1 bit releases it.
- R5: If a released (1) address bit reads back 0, the block drives no further address bits in that frame. It pulses the lose strobe for one cycle after that slot.
- R6: A block that reads back all address bits without error pulses the win strobe for one cycle after the last address slot, and bus ownership rises. Against a contender, the lower address wins.
- R7: While it owns the bus and a request is pending, the block pulls the flag slot low in each frame and does not arbitrate. When it samples the flag slot with no request pending, it releases ownership.
- R8: The function is enabled only when mode bits [2:1] are 00. With any other mode the block never pulls the line and ownership is cleared.
- R9: After a lost arbitration, the block arbitrates again in the next frame whose flag reads free while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe at the end of each bit slot; the line is sampled here |
| frame_end | input | 1 | High with bit_stb on the last slot of a frame |
| line_in | input | 1 | Value read back from the wired-AND line |
| mode_sel | input | 3 | Mode field; arbitration enabled for 00x |
| arb_addr | input | 3 | Own arbitration address |
| sw_req | input | 1 | Software access request |
| tx_req | input | 1 | Pending data-channel frame request |
| line_pull | output | 1 | 1 pulls the line low; 0 releases it |
| win_stb | output | 1 | One-cycle pulse when arbitration is won |
| lose_stb | output | 1 | One-cycle pulse when arbitration is lost |
| bus_owned | output | 1 | The block holds the bus |

## Verification
The bench builds the block with a 32-bit frame and the arbitration octet at index 3. A whole frame then takes only 64 clocks, so a few hundred frames fit in the run. Because the octet sits at the very end of the frame, the last address slot coincides with the frame-end strobe, which makes the win and lose strobes land across the frame boundary. A modelled rival contender with its own address, plus an external busy owner, bring the wired-AND outcome into reach: early and late withdrawal, retries after a loss, holding the bus and releasing it. Each outcome is compared against a closed-form lowest-address rule.

// File: rtl/odbus_arbiter.sv
module odbus_arbiter #(
  parameter int FRAME_BITS = 96,
  parameter int ARB_OCTET  = 11,
  parameter int ADDR_W     = 3,
  parameter int FLAG_BIT   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_stb,
  input  logic        frame_end,
  input  logic        line_in,
  input  logic [2:0]  mode_sel,
  input  logic [ADDR_W-1:0] arb_addr,
  input  logic        sw_req,
  input  logic        tx_req,
  output logic        line_pull,
  output logic        win_stb,
  output logic        lose_stb,
  output logic        bus_owned
);
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int ARB_BASE   = ARB_OCTET * 8;
  localparam int FLAG_SLOT  = ARB_BASE + 7 - FLAG_BIT;
  localparam int ADDR_FIRST = ARB_BASE + 8 - ADDR_W;
  localparam int LAST_SLOT  = ARB_BASE + 7;

  logic [POS_W-1:0] pos;
  logic synced, owned, active, win_q, lose_q, cur_bit;

  wire en      = (mode_sel[2:1] == 2'b00);
  wire req     = sw_req | tx_req;
  wire at_flag = synced && (pos == POS_W'(FLAG_SLOT));
  wire in_addr = synced && (pos >= POS_W'(ADDR_FIRST)) && (pos <= POS_W'(LAST_SLOT));
  wire at_last = pos == POS_W'(LAST_SLOT);

  always_comb begin
    cur_bit = 1'b1;
    for (int i = 0; i < ADDR_W; i++)
      if (pos == POS_W'(LAST_SLOT - i)) cur_bit = arb_addr[i];
  end

  assign line_pull = en && ((at_flag && owned && req) || (in_addr && active && !cur_bit));
  assign win_stb   = win_q;
  assign lose_stb  = lose_q;
  assign bus_owned = owned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      synced <= 1'b0;
    end else if (bit_stb) begin
      if (frame_end || pos == POS_W'(FRAME_BITS-1)) pos <= '0;
      else pos <= pos + 1'b1;
      if (frame_end) synced <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned  <= 1'b0;
      active <= 1'b0;
      win_q  <= 1'b0;
      lose_q <= 1'b0;
    end else begin
      win_q  <= 1'b0;
      lose_q <= 1'b0;
      if (!en) begin
        owned  <= 1'b0;
        active <= 1'b0;
      end else if (bit_stb) begin
        if (at_flag) begin
          if (owned && !req) owned <= 1'b0;
          if (!owned && req && line_in) active <= 1'b1;
        end else if (in_addr && active) begin
          if (cur_bit && !line_in) begin
            active <= 1'b0;
            lose_q <= 1'b1;
          end else if (at_last) begin
            active <= 1'b0;
            owned  <= 1'b1;
            win_q  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/odbus_arbiter_chk.sv
module odbus_arbiter_chk #(
  parameter int FRAME_BITS = 96,
  parameter int ARB_OCTET  = 11,
  parameter int ADDR_W     = 3,
  parameter int FLAG_BIT   = 5,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input logic clk,
  input logic rst_n,
  input logic [2:0] mode_sel,
  input logic [ADDR_W-1:0] arb_addr,
  input logic sw_req,
  input logic tx_req,
  input logic line_pull,
  input logic win_stb,
  input logic lose_stb,
  input logic bus_owned,
  input logic [POS_W-1:0] pos,
  input logic synced
);
  localparam int ARB_BASE   = ARB_OCTET * 8;
  localparam int FLAG_SLOT  = ARB_BASE + 7 - FLAG_BIT;
  localparam int ADDR_FIRST = ARB_BASE + 8 - ADDR_W;
  localparam int LAST_SLOT  = ARB_BASE + 7;

  logic sent_bit;
  always_comb begin
    sent_bit = 1'b0;
    for (int i = 0; i < ADDR_W; i++)
      if (pos == POS_W'(LAST_SLOT - i)) sent_bit = arb_addr[i];
  end
  wire in_addr = (pos >= POS_W'(ADDR_FIRST)) && (pos <= POS_W'(LAST_SLOT));

  a_r8_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[2:1] != 2'b00) |-> !line_pull);
  a_r8_disabled_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[2:1] != 2'b00) |=> !bus_owned);
  a_r1_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull |-> synced && (pos == POS_W'(FLAG_SLOT) || in_addr));
  a_r4_ones_released: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pull && in_addr) |-> !sent_bit);
  a_r7_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pull && pos == POS_W'(FLAG_SLOT)) |-> (bus_owned && (sw_req || tx_req)));
  a_r6_win_owns: assert property (@(posedge clk) disable iff (!rst_n)
    win_stb |-> bus_owned);
  a_r6_win_single: assert property (@(posedge clk) disable iff (!rst_n)
    win_stb |=> !win_stb);
  a_r5_win_lose_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_stb && lose_stb));
endmodule

bind odbus_arbiter odbus_arbiter_chk #(
  .FRAME_BITS(FRAME_BITS), .ARB_OCTET(ARB_OCTET), .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .arb_addr(arb_addr),
  .sw_req(sw_req), .tx_req(tx_req), .line_pull(line_pull), .win_stb(win_stb),
  .lose_stb(lose_stb), .bus_owned(bus_owned), .pos(pos), .synced(synced)
);

// File: tb/sim_odbus_arbiter.sv
`timescale 1ns/1ps
module sim_odbus_arbiter;
  localparam int FB = 32;
  localparam int AO = 3;
  localparam int FLAG = AO*8 + 2;
  localparam int A0 = AO*8 + 5;

  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, frame_end = 1'b0;
  logic [2:0] mode_sel = 3'b000, arb_addr = 3'd0;
  logic sw_req = 1'b0, tx_req = 1'b0, ext_pull = 1'b0;
  logic line_pull, win_stb, lose_stb, bus_owned;
  wire line_in = ~(line_pull | ext_pull);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit own_b = 0;

  always #5 clk = ~clk;

  odbus_arbiter #(.FRAME_BITS(FB), .ARB_OCTET(AO)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_end(frame_end),
    .line_in(line_in), .mode_sel(mode_sel), .arb_addr(arb_addr),
    .sw_req(sw_req), .tx_req(tx_req), .line_pull(line_pull),
    .win_stb(win_stb), .lose_stb(lose_stb), .bus_owned(bus_owned));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit mode_on(input logic [2:0] m);
    return m[2:1] == 2'b00;
  endfunction

  function automatic bit cf_win(input bit en, input bit rq, input bit own0, input bit busy,
                                input bit rv, input logic [2:0] a, input logic [2:0] r);
    return en && rq && !own0 && !busy && (!rv || a < r);
  endfunction

  task automatic do_frame(input logic [2:0] m, input bit sr, input bit tr,
                          input logic [2:0] a, input bit rv, input logic [2:0] r,
                          input bit busy, input bit unsync);
    bit en = mode_on(m);
    bit rq = sr | tr;
    bit own0, exp_act = 0, exp_win = 0, exp_lose = 0, riv_act = 0;
    bit saw_win = 0, saw_lose = 0, stray = 0, exp_pull, ln;
    @(negedge clk);
    mode_sel = m; sw_req = sr; tx_req = tr; arb_addr = a;
    if (!en) own_b = 0;
    own0 = own_b;
    for (int s = 0; s < FB; s++) begin
      @(negedge clk);
      saw_win |= win_stb; saw_lose |= lose_stb;
      bit_stb = 0; frame_end = 0;
      ext_pull = 0;
      if (s == FLAG) ext_pull = busy;
      else if (s >= A0 && riv_act) ext_pull = !r[FB-1-s];
      @(negedge clk);
      if (unsync) begin
        exp_pull = 0;
      end else if (s == FLAG) begin
        exp_pull = en && own_b && rq;
        chk(line_pull == exp_pull, "R7 flag slot drive", line_pull, exp_pull);
      end else if (s >= A0) begin
        exp_pull = exp_act && !a[FB-1-s];
        chk(line_pull == exp_pull, "R4/R5 address slot drive", line_pull, exp_pull);
      end else exp_pull = 0;
      if (line_pull != exp_pull) stray = 1;
      ln = line_in;
      if (!unsync && en) begin
        if (s == FLAG) begin
          riv_act = rv && ln;
          if (own_b && !rq) own_b = 0;
          else if (!own_b && rq && ln) exp_act = 1;
        end else if (s >= A0) begin
          if (riv_act && r[FB-1-s] && !ln) riv_act = 0;
          if (exp_act && a[FB-1-s] && !ln) begin exp_act = 0; exp_lose = 1; end
          else if (exp_act && s == FB-1) begin exp_act = 0; exp_win = 1; own_b = 1; end
        end
      end
      bit_stb = 1; frame_end = (s == FB-1);
    end
    @(negedge clk);
    saw_win |= win_stb; saw_lose |= lose_stb;
    bit_stb = 0; frame_end = 0; ext_pull = 0;
    chk(!stray, "R1 no drive outside slots", stray, 0);
    chk(saw_win == exp_win, "R6 win strobe", saw_win, exp_win);
    if (!unsync)
      chk(saw_win == cf_win(en, rq, own0, busy, rv, a, r), "R6/R2/R3/R8 lowest address wins",
          saw_win, cf_win(en, rq, own0, busy, rv, a, r));
    chk(saw_lose == exp_lose, "R5 lose strobe", saw_lose, exp_lose);
    chk(bus_owned == own_b, "R7/R8 ownership", bus_owned, own_b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(line_pull == 0 && bus_owned == 0 && win_stb == 0 && lose_stb == 0,
        "R1 reset idle", {line_pull, bus_owned, win_stb, lose_stb}, 0);
    rst_n = 1;
    // R1: before the first frame end nothing is driven
    do_frame(3'b000, 1, 0, 3'd2, 0, 3'd0, 0, 1);
    // R3 software request alone wins a free bus
    do_frame(3'b000, 1, 0, 3'd5, 0, 3'd0, 0, 0);
    // R7 hold the bus, then release when requests drop
    do_frame(3'b001, 0, 1, 3'd5, 1, 3'd1, 0, 0);
    do_frame(3'b000, 0, 0, 3'd5, 0, 3'd0, 0, 0);
    // R5 lose on first bit (4 vs 3), R9 retry next frame and win
    do_frame(3'b000, 0, 1, 3'd4, 1, 3'd3, 0, 0);
    do_frame(3'b000, 0, 1, 3'd4, 0, 3'd0, 0, 0);
    do_frame(3'b000, 0, 0, 3'd4, 0, 3'd0, 0, 0);
    // R6 3 beats 4; 7 loses to 6 on last bit; 0 beats 1
    do_frame(3'b000, 1, 1, 3'd3, 1, 3'd4, 0, 0);
    do_frame(3'b000, 0, 0, 3'd3, 0, 3'd0, 0, 0);
    do_frame(3'b000, 0, 1, 3'd7, 1, 3'd6, 0, 0);
    do_frame(3'b000, 1, 0, 3'd0, 1, 3'd1, 0, 0);
    // R8 mode off clears ownership and silences the line
    do_frame(3'b100, 1, 0, 3'd0, 0, 3'd0, 0, 0);
    // R2 busy flag blocks arbitration
    do_frame(3'b000, 1, 1, 3'd0, 0, 3'd0, 1, 0);
    for (int k = 0; k < 260; k++) begin
      logic [2:0] m = ($urandom % 5 == 0) ? 3'($urandom_range(2, 7)) : 3'($urandom_range(0, 1));
      logic [2:0] a = 3'($urandom);
      logic [2:0] r = 3'($urandom);
      bit rv = $urandom % 2;
      if (r == a) r = a + 3'd1;
      do_frame(m, ($urandom % 3) == 0, ($urandom % 3) != 2, a, rv, r, ($urandom % 7) == 0, 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule